// File: doc/BRIEF.md
# Scaled-Index Load/Store Unit

This unit carries out one 32-bit memory transfer per request, addressing memory at a base register value plus an index register value shifted left by zero to three places. A decoder hands it a request: direction (load or store), access size and signedness, the three register numbers (base, index, transfer) with their values, the shift amount, and whether the instruction is conditional and, if so, whether it closes its conditional block. The unit computes the address, checks the operands against the legal forms, issues at most one memory beat, and returns a single response. That response carries the extended load value, a branch request when a word is loaded into the program counter, and fault and illegal flags. The unit never writes condition flags.

All three data paths are valid/ready. The request side is ready only while the unit is idle, so the unit holds one request at a time. On the memory side the unit keeps address, byte enables, write data and direction steady while `mem_valid` is high and `mem_ready` is low. Read data is sampled on the cycle both are high. On the response side every response field holds steady while `rsp_valid` is high and `rsp_ready` is low. A new request is accepted only after the response handshake.

Top module: `regoff_lsu`

## Requirements
- R1: The memory address equals the base value plus the index value shifted left by the 2-bit shift field (0 to 3).
- R2: Access codes are 0 unsigned byte, 1 signed byte, 2 unsigned halfword, 3 signed halfword, 4 word. Memory is little-endian. A byte store enables the one lane chosen by address bits [1:0]. A halfword store enables lanes 1:0 or 3:2, chosen by address bit 1. A word store enables all four lanes. Byte and halfword store data is repeated across the bus.
- R3: Unsigned byte and halfword loads take their lane from the read data and zero-extend it to 32 bits.
- R4: Signed byte and halfword loads take their lane and sign-extend it to 32 bits.
- R5: A store with a signed access code, or any access code above 4, raises the illegal flag.
- R6: A base register 15, or an index register 13 or 15, raises the illegal flag. No memory beat is issued. The illegal flag takes precedence over alignment.
- R7: Transfer register 13 is legal only for word accesses. Transfer register 15 is legal only for a word load. Any other use raises the illegal flag.
- R8: For a word load into register 15, a loaded bit 0 of 1 requests a branch to the loaded value with bit 0 cleared. A loaded bit 0 of 0 raises the program-counter fault and requests no branch. The response data carries the raw loaded word.
- R9: A conditional word load into register 15 that is not the last instruction of its conditional block raises the illegal flag. When it is the last instruction, it behaves as in R8.
- R10: A halfword access with address bit 0 set, or a word access with either of address bits [1:0] set, raises the alignment fault. No memory beat is issued.
- R11: After reset, `req_ready` is high and both `mem_valid` and `rsp_valid` are low. `req_ready` stays low from acceptance until the response handshake. Memory request fields and response fields stay stable while their ready input is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_is_load | input | 1 | 1 load, 0 store |
| req_kind | input | 3 | Access code (R2) |
| req_base_idx | input | 4 | Base register number |
| req_base_val | input | 32 | Base register value |
| req_ofs_idx | input | 4 | Index register number |
| req_ofs_val | input | 32 | Index register value |
| req_xfer_idx | input | 4 | Transfer register number |
| req_xfer_val | input | 32 | Transfer register value (store data) |
| req_shift | input | 2 | Index shift amount |
| req_cond | input | 1 | Instruction is conditional |
| req_cond_last | input | 1 | Instruction closes its conditional block |
| mem_valid | output | 1 | Memory beat requested |
| mem_ready | input | 1 | Memory accepts beat, read data valid |
| mem_write | output | 1 | Beat is a write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 32 | Extended load value, 0 for stores and faults |
| rsp_branch | output | 1 | Branch requested |
| rsp_target | output | 32 | Branch target, bit 0 cleared |
| rsp_illegal | output | 1 | Operand combination not permitted |
| rsp_align_fault | output | 1 | Misaligned access |
| rsp_pc_fault | output | 1 | Program-counter load with bit 0 clear |

## Verification
Two checks can trip on the same request: the operand legality check and the alignment check. The bench sends a word store to an address ending in binary 10 whose index register is 15, and expects only the illegal flag, with `mem_valid` staying low. A second pairing is the program-counter load and the conditional-block rule. The same word load into register 15 is issued once as a closing conditional instruction, which must branch, and once as a non-closing one, which must be illegal with no memory beat.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [2:0] {
    ACC_UB = 3'd0,
    ACC_SB = 3'd1,
    ACC_UH = 3'd2,
    ACC_SH = 3'd3,
    ACC_W  = 3'd4
  } acc_e;

  localparam int          RIDX_W = 4;
  localparam logic [3:0]  IDX_SP = 4'd13;
  localparam logic [3:0]  IDX_PC = 4'd15;

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int AW  = 32,
  parameter int SHW = 2
) (
  input  logic [AW-1:0]  base_val,
  input  logic [AW-1:0]  ofs_val,
  input  logic [SHW-1:0] shift,
  output logic [AW-1:0]  ea
);
  logic [AW-1:0] scaled;

  always_comb begin
    scaled = ofs_val << shift;
    ea     = base_val + scaled;
  end
endmodule

// File: rtl/lsu_rules.sv
module lsu_rules
  import lsu_pkg::*;
#(
  parameter int LW = 2
) (
  input  logic              is_load,
  input  logic [2:0]        kind,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [RIDX_W-1:0] ofs_idx,
  input  logic [RIDX_W-1:0] xfer_idx,
  input  logic              cond,
  input  logic              cond_last,
  input  logic [LW-1:0]     addr_lo,
  output logic              illegal,
  output logic              misalign,
  output logic              pc_load
);
  logic bad_kind, bad_base, bad_ofs, bad_sp, bad_pc, bad_it, is_half, is_word;

  always_comb begin
    is_word  = (kind == ACC_W);
    is_half  = (kind == ACC_UH) || (kind == ACC_SH);
    pc_load  = is_load && is_word && (xfer_idx == IDX_PC);
    bad_kind = (kind > 3'd4) ||
               (!is_load && ((kind == ACC_SB) || (kind == ACC_SH)));
    bad_base = (base_idx == IDX_PC);
    bad_ofs  = (ofs_idx == IDX_SP) || (ofs_idx == IDX_PC);
    bad_sp   = (xfer_idx == IDX_SP) && !is_word;
    bad_pc   = (xfer_idx == IDX_PC) && !(is_load && is_word);
    bad_it   = pc_load && cond && !cond_last;
    illegal  = bad_kind || bad_base || bad_ofs || bad_sp || bad_pc || bad_it;
    misalign = (is_half && addr_lo[0]) || (is_word && (addr_lo != '0));
  end
endmodule

// File: rtl/lsu_lanes.sv
module lsu_lanes
  import lsu_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int LW = $clog2(NB)
) (
  input  logic [2:0]    st_kind,
  input  logic [LW-1:0] st_lo,
  input  logic [DW-1:0] st_data,
  output logic [NB-1:0] st_be,
  output logic [DW-1:0] st_wdata,
  input  logic [2:0]    ld_kind,
  input  logic [LW-1:0] ld_lo,
  input  logic [DW-1:0] ld_raw,
  output logic [DW-1:0] ld_data
);
  logic [DW-1:0] shifted;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      if (st_kind == ACC_UB || st_kind == ACC_SB) begin
        st_wdata[8*i +: 8] = st_data[7:0];
        st_be[i]           = (st_lo == LW'(i));
      end else if (st_kind == ACC_UH || st_kind == ACC_SH) begin
        st_wdata[8*i +: 8] = st_data[8*(i%2) +: 8];
        st_be[i]           = (st_lo[LW-1:1] == (LW-1)'(i/2));
      end else begin
        st_wdata[8*i +: 8] = st_data[8*i +: 8];
        st_be[i]           = 1'b1;
      end
    end
  end

  always_comb begin
    shifted = ld_raw >> {ld_lo, 3'b000};
    unique case (ld_kind)
      ACC_UB:  ld_data = {{(DW-8){1'b0}}, shifted[7:0]};
      ACC_SB:  ld_data = {{(DW-8){shifted[7]}}, shifted[7:0]};
      ACC_UH:  ld_data = {{(DW-16){1'b0}}, shifted[15:0]};
      ACC_SH:  ld_data = {{(DW-16){shifted[15]}}, shifted[15:0]};
      default: ld_data = ld_raw;
    endcase
  end
endmodule

// File: rtl/regoff_lsu.sv
module regoff_lsu
  import lsu_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SHW = 2,
  localparam int NB = DW / 8,
  localparam int LW = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_load,
  input  logic [2:0]        req_kind,
  input  logic [RIDX_W-1:0] req_base_idx,
  input  logic [DW-1:0]     req_base_val,
  input  logic [RIDX_W-1:0] req_ofs_idx,
  input  logic [DW-1:0]     req_ofs_val,
  input  logic [RIDX_W-1:0] req_xfer_idx,
  input  logic [DW-1:0]     req_xfer_val,
  input  logic [SHW-1:0]    req_shift,
  input  logic              req_cond,
  input  logic              req_cond_last,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [DW-1:0]     mem_addr,
  output logic [NB-1:0]     mem_be,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_data,
  output logic              rsp_branch,
  output logic [DW-1:0]     rsp_target,
  output logic              rsp_illegal,
  output logic              rsp_align_fault,
  output logic              rsp_pc_fault
);
  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_RSP} st_e;

  st_e           st_q;
  logic [DW-1:0] ea, wdata_c, ld_c;
  logic [NB-1:0] be_c;
  logic          illegal_c, misalign_c, pcld_c, accept;

  logic [DW-1:0] addr_q, wdata_q, data_q, target_q;
  logic [NB-1:0] be_q;
  logic [2:0]    kind_q;
  logic          write_q, pcld_q, branch_q, ill_q, al_q, pcf_q;

  lsu_agen #(.AW(DW), .SHW(SHW)) u_agen (
    .base_val (req_base_val),
    .ofs_val  (req_ofs_val),
    .shift    (req_shift),
    .ea       (ea)
  );

  lsu_rules #(.LW(LW)) u_rules (
    .is_load   (req_is_load),
    .kind      (req_kind),
    .base_idx  (req_base_idx),
    .ofs_idx   (req_ofs_idx),
    .xfer_idx  (req_xfer_idx),
    .cond      (req_cond),
    .cond_last (req_cond_last),
    .addr_lo   (ea[LW-1:0]),
    .illegal   (illegal_c),
    .misalign  (misalign_c),
    .pc_load   (pcld_c)
  );

  lsu_lanes #(.DW(DW)) u_lanes (
    .st_kind  (req_kind),
    .st_lo    (ea[LW-1:0]),
    .st_data  (req_xfer_val),
    .st_be    (be_c),
    .st_wdata (wdata_c),
    .ld_kind  (kind_q),
    .ld_lo    (addr_q[LW-1:0]),
    .ld_raw   (mem_rdata),
    .ld_data  (ld_c)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
      kind_q   <= '0;
      write_q  <= 1'b0;
      pcld_q   <= 1'b0;
      data_q   <= '0;
      target_q <= '0;
      branch_q <= 1'b0;
      ill_q    <= 1'b0;
      al_q     <= 1'b0;
      pcf_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          addr_q   <= ea;
          be_q     <= be_c;
          wdata_q  <= req_is_load ? '0 : wdata_c;
          write_q  <= !req_is_load;
          kind_q   <= req_kind;
          pcld_q   <= pcld_c;
          data_q   <= '0;
          target_q <= '0;
          branch_q <= 1'b0;
          pcf_q    <= 1'b0;
          ill_q    <= illegal_c;
          al_q     <= !illegal_c && misalign_c;
          st_q     <= (illegal_c || misalign_c) ? ST_RSP : ST_MEM;
        end
        ST_MEM: if (mem_ready) begin
          if (!write_q) data_q <= ld_c;
          if (pcld_q) begin
            if (ld_c[0]) begin
              branch_q <= 1'b1;
              target_q <= {ld_c[DW-1:1], 1'b0};
            end else begin
              pcf_q <= 1'b1;
            end
          end
          st_q <= ST_RSP;
        end
        ST_RSP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid       = (st_q == ST_MEM);
  assign mem_write       = write_q;
  assign mem_addr        = addr_q;
  assign mem_be          = be_q;
  assign mem_wdata       = wdata_q;
  assign rsp_valid       = (st_q == ST_RSP);
  assign rsp_data        = data_q;
  assign rsp_branch      = branch_q;
  assign rsp_target      = target_q;
  assign rsp_illegal     = ill_q;
  assign rsp_align_fault = al_q;
  assign rsp_pc_fault    = pcf_q;

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
      $stable(mem_be) && $stable(mem_wdata) && $stable(mem_write));

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) &&
      $stable(rsp_branch) && $stable(rsp_target) && $stable(rsp_illegal) &&
      $stable(rsp_align_fault) && $stable(rsp_pc_fault));

  p_be_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                   $countones(mem_be) == NB));

  p_word_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && (mem_be == '1) |-> (mem_addr[LW-1:0] == '0));

  p_half_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && ($countones(mem_be) == 2) |-> !mem_addr[0]);

  p_fault_no_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && (rsp_illegal || rsp_align_fault) |-> $past(req_ready));

  p_branch_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_branch |-> !rsp_target[0] && rsp_data[0] &&
      !rsp_pc_fault && !rsp_illegal);
endmodule

// File: tb/regoff_lsu_tb_top.sv
`timescale 1ns/1ps
module regoff_lsu_tb_top;

  typedef struct packed {
    logic [31:0] tag;
    logic        ld;
    logic [2:0]  kind;
    logic [3:0]  rn;
    logic [31:0] rnv;
    logic [3:0]  rm;
    logic [31:0] rmv;
    logic [3:0]  rt;
    logic [31:0] rtv;
    logic [1:0]  sh;
    logic        cnd;
    logic        lst;
    logic [31:0] rd;
    logic        mem;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] data;
    logic        br;
    logic [31:0] tgt;
    logic        ill;
    logic        al;
    logic        pcf;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{"R1", 0,4, 5,32'h1000, 1,32'h10, 0,32'hDEADBEEF, 0,0,0, 32'h0,        1,32'h1010,4'hF,32'hDEADBEEF, 32'h0,        0,32'h0,    0,0,0},
    '{"R2", 0,0, 5,32'h2000, 1,32'h3,  2,32'h12345678, 0,0,0, 32'h0,        1,32'h2003,4'h8,32'h78787878, 32'h0,        0,32'h0,    0,0,0},
    '{"R2", 0,2, 5,32'h100,  1,32'h1,  2,32'hAAAA5566, 1,0,0, 32'h0,        1,32'h102, 4'hC,32'h55665566, 32'h0,        0,32'h0,    0,0,0},
    '{"R3", 1,0, 5,32'h300,  1,32'h1,  0,32'h0,        0,0,0, 32'h11228344, 1,32'h301, 4'h2,32'h0,       32'h83,       0,32'h0,    0,0,0},
    '{"R4", 1,1, 5,32'h300,  1,32'h1,  0,32'h0,        0,0,0, 32'h11228344, 1,32'h301, 4'h2,32'h0,       32'hFFFFFF83, 0,32'h0,    0,0,0},
    '{"R3", 1,2, 5,32'h400,  1,32'h1,  0,32'h0,        1,0,0, 32'h80017FFF, 1,32'h402, 4'hC,32'h0,       32'h8001,     0,32'h0,    0,0,0},
    '{"R4", 1,3, 5,32'h400,  1,32'h1,  0,32'h0,        1,0,0, 32'h80017FFF, 1,32'h402, 4'hC,32'h0,       32'hFFFF8001, 0,32'h0,    0,0,0},
    '{"R1", 1,4, 5,32'h1000, 1,32'h3,  0,32'h0,        2,0,0, 32'hCAFEF00D, 1,32'h100C,4'hF,32'h0,       32'hCAFEF00D, 0,32'h0,    0,0,0},
    '{"R1", 1,4, 5,32'h0,    1,32'h2,  0,32'h0,        3,0,0, 32'h01234567, 1,32'h10,  4'hF,32'h0,       32'h01234567, 0,32'h0,    0,0,0},
    '{"R4", 1,1, 5,32'h300,  1,32'h0,  0,32'h0,        0,0,0, 32'h11228344, 1,32'h300, 4'h1,32'h0,       32'h44,       0,32'h0,    0,0,0},
    '{"R4", 1,3, 5,32'h400,  1,32'h0,  0,32'h0,        0,0,0, 32'h80017FFF, 1,32'h400, 4'h3,32'h0,       32'h7FFF,     0,32'h0,    0,0,0},
    '{"R5", 0,1, 5,32'h100,  1,32'h0,  0,32'h0,        0,0,0, 32'h0,        0,32'h0,   4'h0,32'h0,       32'h0,        0,32'h0,    1,0,0},
    '{"R5", 1,5, 5,32'h100,  1,32'h0,  0,32'h0,        0,0,0, 32'h0,        0,32'h0,   4'h0,32'h0,       32'h0,        0,32'h0,    1,0,0},
    '{"R6", 1,4,15,32'h100,  1,32'h0,  0,32'h0,        0,0,0, 32'h0,        0,32'h0,   4'h0,32'h0,       32'h0,        0,32'h0,    1,0,0},
    '{"R6", 1,4, 5,32'h100, 13,32'h0,  0,32'h0,        0,0,0, 32'h0,        0,32'h0,   4'h0,32'h0,       32'h0,        0,32'h0,    1,0,0},
    '{"R6", 1,4, 5,32'h100, 15,32'h0,  0,32'h0,        0,0,0, 32'h0,        0,32'h0,   4'h0,32'h0,       32'h0,        0,32'h0,    1,0,0},
    '{"R7", 0,0, 5,32'h200,  1,32'h0, 13,32'h55,       0,0,0, 32'h0,        0,32'h0,   4'h0,32'h0,       32'h0,        0,32'h0,    1,0,0},
    '{"R7", 0,4, 5,32'h20,   1,32'h0, 13,32'h0000FF00, 0,0,0, 32'h0,        1,32'h20,  4'hF,32'h0000FF00, 32'h0,        0,32'h0,    0,0,0},
    '{"R7", 0,4, 5,32'h20,   1,32'h0, 15,32'h1,        0,0,0, 32'h0,        0,32'h0,   4'h0,32'h0,       32'h0,        0,32'h0,    1,0,0},
    '{"R7", 1,2, 5,32'h20,   1,32'h0, 15,32'h0,        0,0,0, 32'h0,        0,32'h0,   4'h0,32'h0,       32'h0,        0,32'h0,    1,0,0},
    '{"R8", 1,4, 5,32'h8000, 1,32'h4, 15,32'h0,        0,0,0, 32'h00001235, 1,32'h8004,4'hF,32'h0,       32'h1235,     1,32'h1234, 0,0,0},
    '{"R8", 1,4, 5,32'h8000, 1,32'h4, 15,32'h0,        0,0,0, 32'h00001234, 1,32'h8004,4'hF,32'h0,       32'h1234,     0,32'h0,    0,0,1},
    '{"R9", 1,4, 5,32'h8000, 1,32'h8, 15,32'h0,        0,1,0, 32'h00004001, 0,32'h0,   4'h0,32'h0,       32'h0,        0,32'h0,    1,0,0},
    '{"R9", 1,4, 5,32'h8000, 1,32'h8, 15,32'h0,        0,1,1, 32'h00004001, 1,32'h8008,4'hF,32'h0,       32'h4001,     1,32'h4000, 0,0,0},
    '{"R10",1,2, 5,32'h101,  1,32'h0,  0,32'h0,        0,0,0, 32'h0,        0,32'h0,   4'h0,32'h0,       32'h0,        0,32'h0,    0,1,0},
    '{"R10",1,4, 5,32'h100,  1,32'h2,  0,32'h0,        0,0,0, 32'h0,        0,32'h0,   4'h0,32'h0,       32'h0,        0,32'h0,    0,1,0},
    '{"R6", 0,4, 5,32'h100, 15,32'h2,  0,32'h0,        0,0,0, 32'h0,        0,32'h0,   4'h0,32'h0,       32'h0,        0,32'h0,    1,0,0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_is_load = 1'b0, req_cond = 1'b0, req_cond_last = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [3:0]  req_base_idx = '0, req_ofs_idx = '0, req_xfer_idx = '0;
  logic [31:0] req_base_val = '0, req_ofs_val = '0, req_xfer_val = '0;
  logic [1:0]  req_shift = '0;
  logic        mem_ready = 1'b0, rsp_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        req_ready, mem_valid, mem_write, rsp_valid;
  logic        rsp_branch, rsp_illegal, rsp_align_fault, rsp_pc_fault;
  logic [31:0] mem_addr, mem_wdata, rsp_data, rsp_target;
  logic [3:0]  mem_be;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  regoff_lsu dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_is_load (req_is_load),
    .req_kind (req_kind),
    .req_base_idx (req_base_idx), .req_base_val (req_base_val),
    .req_ofs_idx (req_ofs_idx), .req_ofs_val (req_ofs_val),
    .req_xfer_idx (req_xfer_idx), .req_xfer_val (req_xfer_val),
    .req_shift (req_shift), .req_cond (req_cond), .req_cond_last (req_cond_last),
    .mem_valid (mem_valid), .mem_ready (mem_ready), .mem_write (mem_write),
    .mem_addr (mem_addr), .mem_be (mem_be), .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_data (rsp_data),
    .rsp_branch (rsp_branch), .rsp_target (rsp_target),
    .rsp_illegal (rsp_illegal), .rsp_align_fault (rsp_align_fault),
    .rsp_pc_fault (rsp_pc_fault)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(req_ready === 1'b1, "R11", "req_ready in reset", 32'(req_ready), 32'h1);
    chk(mem_valid === 1'b0, "R11", "mem_valid in reset", 32'(mem_valid), 32'h0);
    chk(rsp_valid === 1'b0, "R11", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R11", "req_ready after reset", 32'(req_ready), 32'h1);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      string t;
      int w;
      v = VECS[k];
      t = $sformatf("%s", v.tag);
      req_is_load = v.ld;   req_kind = v.kind;
      req_base_idx = v.rn;  req_base_val = v.rnv;
      req_ofs_idx = v.rm;   req_ofs_val = v.rmv;
      req_xfer_idx = v.rt;  req_xfer_val = v.rtv;
      req_shift = v.sh;     req_cond = v.cnd; req_cond_last = v.lst;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(mem_valid === v.mem, t, $sformatf("vec %0d mem_valid", k), 32'(mem_valid), 32'(v.mem));
      if (mem_valid) begin
        chk(mem_addr === v.addr, t, $sformatf("vec %0d addr", k), mem_addr, v.addr);
        chk(mem_be === v.be, t, $sformatf("vec %0d be", k), 32'(mem_be), 32'(v.be));
        chk(mem_write === !v.ld, t, $sformatf("vec %0d write", k), 32'(mem_write), 32'(!v.ld));
        if (!v.ld)
          chk(mem_wdata === v.wd, t, $sformatf("vec %0d wdata", k), mem_wdata, v.wd);
        chk(req_ready === 1'b0, "R11", "req_ready while busy", 32'(req_ready), 32'h0);
        @(negedge clk);
        chk(mem_valid === 1'b1 && mem_addr === v.addr, "R11", "mem hold under stall",
            mem_addr, v.addr);
        mem_rdata = v.rd;
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        mem_rdata = '0;
      end
      w = 0;
      while (rsp_valid !== 1'b1 && w < 20) begin
        @(negedge clk);
        w++;
      end
      chk(rsp_valid === 1'b1, t, $sformatf("vec %0d rsp_valid", k), 32'(rsp_valid), 32'h1);
      @(negedge clk);
      chk(rsp_valid === 1'b1 && req_ready === 1'b0, "R11", "rsp hold under stall",
          32'(rsp_valid), 32'h1);
      chk(rsp_data === v.data, t, $sformatf("vec %0d data", k), rsp_data, v.data);
      chk(rsp_branch === v.br, t, $sformatf("vec %0d branch", k), 32'(rsp_branch), 32'(v.br));
      if (v.br)
        chk(rsp_target === v.tgt, t, $sformatf("vec %0d target", k), rsp_target, v.tgt);
      chk(rsp_illegal === v.ill, t, $sformatf("vec %0d illegal", k), 32'(rsp_illegal), 32'(v.ill));
      chk(rsp_align_fault === v.al, t, $sformatf("vec %0d align", k), 32'(rsp_align_fault), 32'(v.al));
      chk(rsp_pc_fault === v.pcf, t, $sformatf("vec %0d pcfault", k), 32'(rsp_pc_fault), 32'(v.pcf));
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R11", "idle after rsp",
          32'(req_ready), 32'h1);
    end

    // R11: request held while busy is not taken twice
    req_is_load = 1'b1; req_kind = 3'd4; req_base_idx = 4'd5; req_base_val = 32'h40;
    req_ofs_idx = 4'd1; req_ofs_val = 32'h1; req_shift = 2'd2; req_xfer_idx = 4'd0;
    req_cond = 1'b0; req_cond_last = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    chk(mem_valid === 1'b1 && mem_addr === 32'h44, "R1", "held request addr", mem_addr, 32'h44);
    @(negedge clk);
    chk(req_ready === 1'b0, "R11", "no second accept", 32'(req_ready), 32'h0);
    req_valid = 1'b0;
    mem_rdata = 32'h0BADF00D; mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0; rsp_ready = 1'b1;
    chk(rsp_data === 32'h0BADF00D, "R1", "held request data", rsp_data, 32'h0BADF00D);
    @(negedge clk);
    rsp_ready = 1'b0;
    @(negedge clk);
    chk(mem_valid === 1'b0 && rsp_valid === 1'b0, "R11", "single transfer only",
        32'(mem_valid | rsp_valid), 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule